// File: doc/BRIEF.md
# Run-time switchable carry-select adder/subtractor

This block adds or subtracts two unsigned operands of `WIDTH` bits (10 by default). The operation is picked on every cycle by one shared mode pin. Each bit is a small cell built from four two-input functions. Two of them give the sum bit for a local carry of 0 and of 1. The other two give the carry-out for those same two cases.

Two carry chains run through all the cells side by side. Chain 0 starts at bit 0 with the value of the mode pin, and chain 1 starts with its inverse. The group carry-in picks one of the two chains. At each bit, the level of the picked chain then chooses which of the cell's two precomputed sums is sent out. In subtract mode the second operand is inverted inside each cell, and the group carry-in acts as a borrow-in.

The result is available in two forms: combinationally in the same cycle, and through an output register. The register shares one clock, one enable and one active-low asynchronous clear. Both interfaces are plain wires with no handshake. A new operand set may be applied every cycle, and the block never stalls.

Top module: `csel_addsub`

## Requirements
- R1: With `sub_mode`=0, `{cout_comb, sum_comb}` equals `opa + opb + grp_cin` as a `WIDTH+1`-bit result in the same cycle.
- R2: With `sub_mode`=1, `{cout_comb, sum_comb}` equals `opa + ~opb + (1 - grp_cin)` as a `WIDTH+1`-bit result. So `sum_comb` = `opa - opb - grp_cin` modulo 2^WIDTH, and `cout_comb`=1 exactly when `opa >= opb + grp_cin` (no borrow).
- R3: A change of `sub_mode` alone, with the operands held, changes the combinational result in that same cycle to the value for the new mode.
- R4: Chain 0 carries the mode value into bit 0 and chain 1 carries its inverse. At every bit the chain that starts at 1 is at least as high as the other one. `grp_cin`=1 selects chain 1 for all sum bits and for the carry-out.
- R5: A carry that ripples through every bit is correct. Adding all ones, zero and `grp_cin`=1 gives sum 0 with carry-out 1.
- R6: Subtracting zero from zero with a borrow-in (`sub_mode`=1, `grp_cin`=1) gives all ones with carry-out 0.
- R7: At a rising clock edge with `ena`=1 and `rst_n`=1, `sum_q`/`cout_q` take the combinational result of that cycle, one cycle after the inputs were applied.
- R8: At a rising edge with `ena`=0, `sum_q`/`cout_q` keep their value.
- R9: `rst_n`=0 clears `sum_q` and `cout_q` to 0 at once, without waiting for a clock edge, and keeps them at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the output register |
| rst_n | input | 1 | Active-low asynchronous clear of the output register |
| ena | input | 1 | Load enable of the output register |
| sub_mode | input | 1 | 0 = add, 1 = subtract (shared by all bits) |
| grp_cin | input | 1 | Group carry-in; acts as borrow-in when subtracting |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| sum_comb | output | WIDTH | Combinational sum or difference |
| cout_comb | output | 1 | Combinational carry-out of the selected chain |
| sum_q | output | WIDTH | Registered sum or difference |
| cout_q | output | 1 | Registered carry-out |

## Verification
The combinational outputs are due in the same cycle as their inputs. The bench drives inputs at the falling edge and compares `sum_comb`/`cout_comb` against its behavioural model 1 ns later, well before the next rising edge. The registered outputs are due one rising edge later. They are compared 1 ns after that edge against a model register that loads only when the enable is high. The asynchronous clear is checked mid-cycle, between clock edges, so that it cannot be mistaken for a clocked clear.

// File: rtl/csel_pkg.sv
package csel_pkg;

  // Levels of the two parallel carry chains at one bit boundary.
  typedef struct packed {
    logic c0;  // chain launched with the mode value
    logic c1;  // chain launched with the inverse of the mode value
  } carry_pair_t;

endpackage

// File: rtl/csel_cell.sv
module csel_cell
  import csel_pkg::*;
(
  input  logic        a_bit,
  input  logic        b_bit,
  input  logic        sub,
  input  logic        grp_cin,
  input  carry_pair_t cin_pair,
  output carry_pair_t cout_pair,
  output logic        sum_bit
);

  logic b_eff;
  logic sum_if0, sum_if1;   // sum tables for a local carry of 0 and of 1
  logic kry_if0, kry_if1;   // carry tables for a local carry of 0 and of 1
  logic sel_carry;

  // Operand inversion for subtraction.
  assign b_eff = b_bit ^ sub;

  // Four two-input functions of (a_bit, b_eff).
  assign sum_if0 = a_bit ^ b_eff;
  assign sum_if1 = ~(a_bit ^ b_eff);
  assign kry_if0 = a_bit & b_eff;
  assign kry_if1 = a_bit | b_eff;

  // Each chain steers its own carry table.
  assign cout_pair.c0 = cin_pair.c0 ? kry_if1 : kry_if0;
  assign cout_pair.c1 = cin_pair.c1 ? kry_if1 : kry_if0;

  // The group carry picks a chain; that chain's level picks the sum.
  assign sel_carry = grp_cin ? cin_pair.c1 : cin_pair.c0;
  assign sum_bit   = sel_carry ? sum_if1 : sum_if0;

endmodule

// File: rtl/csel_chain.sv
module csel_chain
  import csel_pkg::*;
#(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sub,
  input  logic             grp_cin,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  localparam int NLINK = WIDTH + 1;

  carry_pair_t link [NLINK];

  // Chain 0 starts with the mode value, chain 1 with its inverse.
  assign link[0].c0 = sub;
  assign link[0].c1 = ~sub;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    csel_cell u_cell (
      .a_bit    (a[i]),
      .b_bit    (b[i]),
      .sub      (sub),
      .grp_cin  (grp_cin),
      .cin_pair (link[i]),
      .cout_pair(link[i+1]),
      .sum_bit  (sum[i])
    );

    // The chain launched at 1 dominates the one launched at 0 at every bit.
    AST_CHAIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (sub ? (link[i+1].c0 || !link[i+1].c1) : (link[i+1].c1 || !link[i+1].c0))) // R4
      else $error("chain order broken at bit %0d", i);
  end

  assign cout = grp_cin ? link[WIDTH].c1 : link[WIDTH].c0;

endmodule

// File: rtl/csel_outreg.sv
module csel_outreg #(
  parameter int DW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ena,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (ena) q <= d;
  end

  AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ena |=> q == $past(d)) // R7
    else $error("register missed a capture");

  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ena |=> $stable(q)) // R8
    else $error("register changed while disabled");

  AST_REG_CLEAR: assert property (@(posedge clk)
    !rst_n |-> q == '0) // R9
    else $error("register not cleared");

endmodule

// File: rtl/csel_addsub.sv
module csel_addsub #(
  parameter int WIDTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ena,
  input  logic             sub_mode,
  input  logic             grp_cin,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] sum_comb,
  output logic             cout_comb,
  output logic [WIDTH-1:0] sum_q,
  output logic             cout_q
);

  localparam int RW = WIDTH + 1;

  logic [RW-1:0] res_q;

  csel_chain #(.WIDTH(WIDTH)) u_chain (
    .clk    (clk),
    .rst_n  (rst_n),
    .sub    (sub_mode),
    .grp_cin(grp_cin),
    .a      (opa),
    .b      (opb),
    .sum    (sum_comb),
    .cout   (cout_comb)
  );

  csel_outreg #(.DW(RW)) u_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .ena  (ena),
    .d    ({cout_comb, sum_comb}),
    .q    (res_q)
  );

  assign sum_q  = res_q[WIDTH-1:0];
  assign cout_q = res_q[WIDTH];

  // Arithmetic references for the assertions below.
  logic [RW-1:0] add_ref, sub_ref;
  assign add_ref = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, grp_cin};
  assign sub_ref = {1'b0, opa} + {1'b0, ~opb} + {{WIDTH{1'b0}}, ~grp_cin};

  AST_ADD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_mode |-> {cout_comb, sum_comb} == add_ref) // R1
    else $error("add result wrong");

  AST_SUB_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    sub_mode |-> {cout_comb, sum_comb} == sub_ref) // R2
    else $error("subtract result wrong");

endmodule

// File: tb/tb_csel_addsub.sv
`timescale 1ns/1ps
module tb_csel_addsub;

  localparam int W    = 10;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ena = 1'b0;
  logic         sub_mode = 1'b0;
  logic         grp_cin = 1'b0;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic [W-1:0] sum_comb, sum_q;
  logic         cout_comb, cout_q;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  int exp_q = 0;   // model register: {cout, sum}

  always #2.5 clk = ~clk;

  csel_addsub #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .ena(ena), .sub_mode(sub_mode), .grp_cin(grp_cin),
    .opa(opa), .opb(opb), .sum_comb(sum_comb), .cout_comb(cout_comb),
    .sum_q(sum_q), .cout_q(cout_q)
  );

  function automatic int model(int a, int b, int cin, int sub);
    if (sub == 0) return (a + b + cin) & ((MASK << 1) | 1);
    return (a + ((~b) & MASK) + (1 - cin)) & ((MASK << 1) | 1);
  endfunction

  task automatic chk(string req, int got, int exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // One cycle: drive at the falling edge, check the combinational result,
  // then check the register after the rising edge.
  task automatic step(string req, int a, int b, int cin, int sub, int en);
    int e;
    @(negedge clk);
    opa = a[W-1:0]; opb = b[W-1:0]; grp_cin = cin[0]; sub_mode = sub[0]; ena = en[0];
    e = model(a, b, cin, sub);
    #1;
    chk(req, {cout_comb, sum_comb}, e);
    @(posedge clk);
    if (en != 0) exp_q = e;
    #1;
    chk(en != 0 ? "R7" : "R8", {cout_q, sum_q}, exp_q);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk("R9", {cout_q, sum_q}, 0);               // reset state
    @(negedge clk); rst_n = 1'b1;

    // Directed corners
    step("R1", 3, 5, 0, 0, 1);
    step("R1", 3, 5, 1, 0, 1);
    step("R5", MASK, 0, 1, 0, 1);                 // full ripple: 0, carry 1
    step("R5", MASK, MASK, 1, 0, 1);
    step("R6", 0, 0, 1, 1, 1);                    // all ones, carry 0
    step("R2", 7, 7, 0, 1, 1);                    // equal: 0, no borrow
    step("R2", 7, 8, 0, 1, 1);
    step("R2", 100, 3, 1, 1, 1);
    // Mode flips with operands held
    step("R3", 300, 200, 0, 0, 1);
    step("R3", 300, 200, 0, 1, 1);
    step("R3", 300, 200, 1, 0, 1);
    step("R3", 300, 200, 1, 1, 1);
    // Enable low keeps register
    step("R8", 11, 22, 0, 0, 0);
    step("R8", 900, 5, 1, 1, 0);
    // Chain selection: all-propagate operands, both carry-ins, both modes
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < 2; c++)
        step("R4", 'h155, (s != 0) ? 'h155 : 'h2AA, c, s, 1);

    // Random sweep
    for (int k = 0; k < 400; k++) begin
      int a, b, c, s, en;
      a = $urandom & MASK;
      b = $urandom & MASK;
      c = $urandom & 1;
      s = $urandom & 1;
      en = (($urandom % 4) != 0) ? 1 : 0;
      step(s != 0 ? "R2" : "R1", a, b, c, s, en);
    end

    // Asynchronous clear between edges
    step("R7", 1000, 1000, 1, 0, 1);
    @(negedge clk);
    #0.5 rst_n = 1'b0;
    #0.5;
    chk("R9", {cout_q, sum_q}, 0);
    @(posedge clk); #1;
    chk("R9", {cout_q, sum_q}, 0);
    exp_q = 0;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule